// File: doc/BRIEF.md
# Bit-Serial Adder with Shift Registers

This block adds two 4-bit numbers one bit position per clock. The first operand (the augend) and the second operand (the addend) each sit in a register that shifts toward its least significant end. On every enabled clock, the bottom bit of each register goes into a full-adder function together with a single stored carry bit. The resulting sum bit enters the top of the augend register, so that register slowly fills with the result. The addend register refills with zeros from the top.

The carry is held in a flip-flop with JK behaviour. It sets when both serial bits are 1, clears when both are 0, and otherwise keeps its value. A controller counts the enabled shifts. After exactly four of them it raises a done flag and freezes the datapath until the next parallel load. A caller loads both operands, holds the shift enable high for four clocks (gaps are allowed) and reads the result word and the carry out once done is high.

Top module: `serial_adder_top`

## Requirements
- R1: When `clr_n` is 0 at a rising clock edge, both operand registers, the carry, the shift count and `done` become 0 at that edge, whatever the values of `load` and `shift_en`.
- R2: When `load` is 1 (and `clr_n` is 1) at an edge, the augend register takes `a_in`, the addend register takes `b_in`, and the carry, shift count and `done` become 0. Load takes priority over `shift_en`, and it also restarts an addition that is in progress.
- R3: On an enabled shift, the augend register moves right by one bit, and its bit 3 takes the XOR of augend bit 0, addend bit 0 and the stored carry. The addend register also moves right by one bit and takes 0 into its bit 3.
- R4: On an enabled shift, the carry becomes 1 if both serial bits are 1, becomes 0 if both are 0, and keeps its value if they differ.
- R5: When `shift_en` is 0 and `load` is 0, both registers, the carry and the shift count keep their values.
- R6: After exactly 4 enabled shifts since a load, `done` is 1, `sum_out` equals (a_in + b_in) mod 16, and `carry_out` equals bit 4 of a_in + b_in. Before the fourth shift, `done` is 0.
- R7: While `done` is 1, `shift_en` has no effect: `sum_out`, `carry_out` and `done` hold until the next load or clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Synchronous clear, active low |
| load | input | 1 | Parallel load of both operands |
| shift_en | input | 1 | Enables one serial add step per clock |
| a_in | input | 4 | Augend value for parallel load |
| b_in | input | 4 | Addend value for parallel load |
| sum_out | output | 4 | Augend register contents; the sum once done |
| carry_out | output | 1 | Stored carry; the carry out once done |
| done | output | 1 | High after four enabled shifts since load |

## Verification
The augend register and the carry are visible at the ports, so a wrong sum bit or a wrong carry update shows on `sum_out` or `carry_out` on the very next edge. The bench checks both after every step against closed-form values: the partial sum of the low k operand bits and the carry into bit k. A fault in the hidden addend register or in the shift count shows up later. It appears as a wrong result bit in a later step, or as `done` rising on the wrong step, and in every case it is visible by the fourth shift. Holds are checked both during idle cycles within an addition and after `done` has risen.

// File: rtl/serial_add_pkg.sv
package serial_add_pkg;

    localparam int SA_WIDTH = 4;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_SHIFT = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } sa_op_e;

    typedef struct packed {
        logic x;     // augend serial bit
        logic y;     // addend serial bit
        logic cin;   // stored carry
    } sa_slice_t;

    function automatic logic fa_sum(input sa_slice_t s);
        return s.x ^ s.y ^ s.cin;
    endfunction

    // JK update: set when both ones, reset when both zeros, hold otherwise
    function automatic logic jk_next(input logic q, input logic x, input logic y);
        logic j, k;
        j = x & y;
        k = ~x & ~y;
        return (j & ~q) | (~k & q);
    endfunction

endpackage

// File: rtl/sa_seq_ctrl.sv
module sa_seq_ctrl
    import serial_add_pkg::*;
#(
    parameter int W = SA_WIDTH
) (
    input  logic   clk,
    input  logic   clr_n,
    input  logic   load,
    input  logic   shift_en,
    output sa_op_e op,
    output logic   done
);
    localparam int CW = $clog2(W + 1);
    localparam logic [CW-1:0] LAST = CW'(W);

    logic [CW-1:0] cnt_q;

    assign done = (cnt_q == LAST);

    always_comb begin
        if (!clr_n)                op = OP_CLEAR;
        else if (load)             op = OP_LOAD;
        else if (shift_en && !done) op = OP_SHIFT;
        else                       op = OP_HOLD;
    end

    always_ff @(posedge clk) begin
        case (op)
            OP_CLEAR, OP_LOAD: cnt_q <= '0;
            OP_SHIFT:          cnt_q <= cnt_q + 1'b1;
            default:           cnt_q <= cnt_q;
        endcase
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!clr_n)
        cnt_q <= LAST); // R6
    AST_DONE_STICKS: assert property (@(posedge clk) disable iff (!clr_n)
        (done && !load) |=> done); // R7
    AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (!clr_n)
        load |=> !done); // R2
endmodule

// File: rtl/sa_shift_reg.sv
module sa_shift_reg
    import serial_add_pkg::*;
#(
    parameter int W = SA_WIDTH
) (
    input  logic         clk,
    input  logic         clr_n,
    input  sa_op_e       op,
    input  logic [W-1:0] par_in,
    input  logic         ser_in,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        case (op)
            OP_CLEAR: q <= '0;
            OP_LOAD:  q <= par_in;
            OP_SHIFT: q <= {ser_in, q[W-1:1]};
            default:  q <= q;
        endcase
    end

    AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!clr_n)
        (op == OP_LOAD) |=> (q == $past(par_in))); // R2
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!clr_n)
        (op == OP_HOLD) |=> $stable(q)); // R5
    AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (!clr_n)
        (op == OP_SHIFT) |=> (q[W-2:0] == $past(q[W-1:1]))); // R3
endmodule

// File: rtl/sa_carry_jk.sv
module sa_carry_jk
    import serial_add_pkg::*;
(
    input  logic   clk,
    input  logic   clr_n,
    input  sa_op_e op,
    input  logic   x,
    input  logic   y,
    output logic   q
);
    always_ff @(posedge clk) begin
        case (op)
            OP_CLEAR, OP_LOAD: q <= 1'b0;
            OP_SHIFT:          q <= jk_next(q, x, y);
            default:           q <= q;
        endcase
    end

    AST_CARRY_SET: assert property (@(posedge clk) disable iff (!clr_n)
        (op == OP_SHIFT && x && y) |=> q); // R4
    AST_CARRY_CLR: assert property (@(posedge clk) disable iff (!clr_n)
        (op == OP_SHIFT && !x && !y) |=> !q); // R4
    AST_CARRY_KEEP: assert property (@(posedge clk) disable iff (!clr_n)
        (op == OP_SHIFT && (x ^ y)) |=> $stable(q)); // R4
    AST_CARRY_LOADZERO: assert property (@(posedge clk) disable iff (!clr_n)
        (op == OP_LOAD) |=> !q); // R2
endmodule

// File: rtl/serial_adder_top.sv
module serial_adder_top
    import serial_add_pkg::*;
#(
    parameter int W = SA_WIDTH
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic         load,
    input  logic         shift_en,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] sum_out,
    output logic         carry_out,
    output logic         done
);
    sa_op_e       op;
    logic [W-1:0] aug_q;
    logic [W-1:0] add_q;
    logic         cy_q;
    sa_slice_t    slice;
    logic         sum_bit;

    assign slice   = '{x: aug_q[0], y: add_q[0], cin: cy_q};
    assign sum_bit = fa_sum(slice);

    sa_seq_ctrl #(.W(W)) u_ctrl (
        .clk(clk), .clr_n(clr_n), .load(load), .shift_en(shift_en),
        .op(op), .done(done)
    );

    sa_shift_reg #(.W(W)) u_augend (
        .clk(clk), .clr_n(clr_n), .op(op), .par_in(a_in),
        .ser_in(sum_bit), .q(aug_q)
    );

    sa_shift_reg #(.W(W)) u_addend (
        .clk(clk), .clr_n(clr_n), .op(op), .par_in(b_in),
        .ser_in(1'b0), .q(add_q)
    );

    sa_carry_jk u_carry (
        .clk(clk), .clr_n(clr_n), .op(op),
        .x(aug_q[0]), .y(add_q[0]), .q(cy_q)
    );

    assign sum_out   = aug_q;
    assign carry_out = cy_q;

    AST_SUM_INTO_TOP: assert property (@(posedge clk) disable iff (!clr_n)
        (shift_en && !load && !done) |=>
        (sum_out[W-1] == ($past(sum_out[0]) ^ $past(add_q[0]) ^ $past(carry_out)))); // R3
    AST_ADDEND_ZEROFILL: assert property (@(posedge clk) disable iff (!clr_n)
        (shift_en && !load && !done) |=> !add_q[W-1]); // R3
    AST_DONE_FREEZE: assert property (@(posedge clk) disable iff (!clr_n)
        (done && !load) |=> ($stable(sum_out) && $stable(carry_out))); // R7
    AST_CLEAR_ALL: assert property (@(posedge clk)
        $past(!clr_n) |-> (sum_out == '0 && !carry_out && !done)); // R1
endmodule

// File: tb/tb_serial_adder_top.sv
module tb_serial_adder_top;
    logic       clk = 1'b0;
    logic       clr_n = 1'b0;
    logic       load = 1'b0;
    logic       shift_en = 1'b0;
    logic [3:0] a_in = '0;
    logic [3:0] b_in = '0;
    logic [3:0] sum_out;
    logic       carry_out;
    logic       done;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    serial_adder_top dut (
        .clk(clk), .clr_n(clr_n), .load(load), .shift_en(shift_en),
        .a_in(a_in), .b_in(b_in), .sum_out(sum_out),
        .carry_out(carry_out), .done(done)
    );

    function automatic logic [3:0] exp_word(int a, int b, int k);
        int m = (1 << k) - 1;
        int s = a + b;
        return 4'(((a >> k) | ((s & m) << (4 - k))) & 15);
    endfunction

    function automatic logic exp_carry(int a, int b, int k);
        int m = (1 << k) - 1;
        if (k == 0) return 1'b0;
        return 1'(((( a & m) + (b & m)) >> k) & 1);
    endfunction

    task automatic chk(string req, logic [3:0] s, logic c, logic d);
        n_chk++;
        if (sum_out !== s || carry_out !== c || done !== d) begin
            n_fail++;
            $display("FAIL %s: got sum=%h c=%b d=%b, expected sum=%h c=%b d=%b",
                     req, sum_out, carry_out, done, s, c, d);
        end
    endtask

    // apply inputs for one clock edge, return at the following falling edge
    task automatic step(logic ld, logic sh, logic [3:0] a, logic [3:0] b);
        load = ld; shift_en = sh; a_in = a; b_in = b;
        @(negedge clk);
        load = 1'b0; shift_en = 1'b0;
    endtask

    task automatic run_add(int a, int b, bit gaps);
        step(1'b1, 1'($urandom_range(0, 1)), 4'(a), 4'(b));
        chk("R2", 4'(a), 1'b0, 1'b0);
        for (int k = 1; k <= 4; k++) begin
            if (gaps && $urandom_range(0, 2) == 0) begin
                step(1'b0, 1'b0, 4'(a), 4'(b));
                chk("R5", exp_word(a, b, k - 1), exp_carry(a, b, k - 1), 1'b0);
            end
            step(1'b0, 1'b1, '0, '0);
            if (k < 4) chk("R3_R4", exp_word(a, b, k), exp_carry(a, b, k), 1'b0);
            else       chk("R6", 4'((a + b) & 15), 1'((a + b) >> 4), 1'b1);
        end
        step(1'b0, 1'b1, '0, '0);
        chk("R7", 4'((a + b) & 15), 1'((a + b) >> 4), 1'b1);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        @(negedge clk);
        chk("R1", 4'h0, 1'b0, 1'b0);
        clr_n = 1'b1;
        // directed corners
        run_add(15, 15, 0);
        run_add(0, 0, 0);
        run_add(15, 1, 1);
        run_add(8, 8, 1);
        run_add(5, 10, 0);
        // load restarts a partial addition (R2)
        step(1'b1, 1'b0, 4'd7, 4'd9);
        step(1'b0, 1'b1, '0, '0);
        step(1'b0, 1'b1, '0, '0);
        step(1'b1, 1'b1, 4'd3, 4'd6);
        chk("R2", 4'd3, 1'b0, 1'b0);
        // clear overrides load (R1)
        step(1'b0, 1'b1, '0, '0);
        clr_n = 1'b0;
        step(1'b1, 1'b1, 4'hF, 4'hF);
        chk("R1", 4'h0, 1'b0, 1'b0);
        clr_n = 1'b1;
        for (int i = 0; i < 60; i++)
            run_add(int'($urandom_range(0, 15)), int'($urandom_range(0, 15)), 1);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule